// File: doc/BRIEF.md
# Multi-Lane Self-Test Engine

This block is a built-in self-test engine for a four-lane serial datapath. Each lane has a symbol generator that emits frames of a fixed number of symbols. Each symbol passes through an internal one-cycle loopback register into a checker, which rebuilds the expected symbol on its own and compares it. Software drives the engine through a small word-addressed register port. The port holds a 16-bit control word plus a set of saturating counters: frames sent, frames received per lane, and symbol errors per lane.

The patterns are simple placeholders that are computed from the pattern type, the lane number and the symbol position in the frame. A stop request does not end a run at once. The generator first finishes the frame it is sending, and the stop bit stays up for a fixed drain time so that the last symbols can reach the checkers. An injection input corrupts the symbol that one chosen lane sends in a given cycle, so that the error path can be exercised. A per-lane pass flag gives the test verdict directly.

Top module: `bist_engine`

## Requirements
- R1: After reset, every register reads 0 and every lane pass flag is 0.
- R2: Control word, address 0: pattern type in bits 11:10 (0 deterministic, 1 random-like, 2 jitter-like, 3 pseudo-random), symbol width in bit 12 (1 = 10-bit, 0 = 8-bit), enable in bit 13. Bits 9:0 read 0. Type and width take a written value only while start and stop are both 0.
- R3: A control write with bit 13 = 1 and bit 15 = 1, made while start and stop are both 0, sets start (bit 15). Start then stays 1 until a stop or a disable is written. Writing 0 to bit 15 has no effect on it.
- R4: A control write with bits 13 and 14 set clears start and sets stop (bit 14). Stop then reads 1 for exactly FRAME_LEN+1 cycles and clears itself.
- R5: A control write with bit 13 = 0 clears enable, start and stop in the same edge and aborts the run.
- R6: Address 1 counts the frames sent. Addresses 2 to 5 count the frames received on lanes 0 to 3. A frame is FRAME_LEN consecutive symbols.
- R7: Addresses 6 to 9 count the symbol errors on lanes 0 to 3. While inj_en is high, bit 0 of the symbol that lane inj_lane sends in that cycle is inverted, and this adds exactly one error. Injection while no symbol is being sent has no effect.
- R8: The write that sets start clears every counter in the same edge.
- R9: Every counter holds at 16'hFFFF instead of wrapping.
- R10: lane_pass[l] is 1 exactly when the error count of lane l is 0 and its received frame count is nonzero.
- R11: Writes to the counter addresses are ignored.
- R12: A frame that is being sent when stop is requested is completed. When stop clears, every lane's received frame count equals the sent frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register word address for reads and writes |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr, combinational |
| inj_en | input | 1 | Invert bit 0 of the selected lane's symbol in this cycle |
| inj_lane | input | LANE_W | Lane selected for error injection |
| lane_pass | output | LANES | Per-lane verdict: no errors and at least one frame |

## Verification
Two functions can fall in the same cycle. A stop request can arrive while a frame is half sent, so the drain of the generator overlaps with error injection. In the same way, an injection can land on the closing symbol of a frame, so an error count and a frame count rise on the same edge. The bench provokes both cases by issuing a stop after an arbitrary run length and by raising injection right after the stop write. A behavioural reference model, updated every clock, judges the resulting error count, the frame counts and the exact fall of the stop bit.

// File: rtl/bist_pkg.sv
package bist_pkg;

  // control word bit positions (software decodes these)
  localparam int B_PAT   = 10;
  localparam int B_WIDE  = 12;
  localparam int B_EN    = 13;
  localparam int B_STOP  = 14;
  localparam int B_START = 15;
  localparam int SYM_W   = 10;

  typedef enum logic [1:0] {
    PAT_DET = 2'd0,
    PAT_RND = 2'd1,
    PAT_JIT = 2'd2,
    PAT_PRS = 2'd3
  } pat_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic en;
    logic wide;
    pat_e pat;
  } ctl_t;

  // placeholder symbol for a lane at a given position in the frame
  function automatic logic [SYM_W-1:0] pat_sym(pat_e p, logic wide,
                                               logic [7:0] lane, logic [7:0] idx);
    logic [SYM_W-1:0] s;
    case (p)
      PAT_DET: s = {2'b01, idx ^ lane};
      PAT_RND: s = {idx[1:0], idx ^ 8'hC3 ^ {lane[3:0], lane[3:0]}};
      PAT_JIT: s = idx[0] ? 10'h17C : {2'b10, ~lane};
      default: s = ({idx, 2'b11} * 10'd37) ^ {2'b00, lane};
    endcase
    if (!wide) s[SYM_W-1:8] = 2'b00;
    return s;
  endfunction

endpackage

// File: rtl/bist_satcnt.sv
module bist_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)                         q_d = '0;
    else if (inc && q != {W{1'b1}})  q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int FRAME_LEN = 8,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [5:0]       wfield,    // control word bits 15:10
  output ctl_t             ctl,
  output logic             tx_valid,
  output logic [IDX_W-1:0] tx_idx,
  output logic             tx_last,
  output logic             clr
);
  localparam int DRN_W = $clog2(FRAME_LEN + 2);
  localparam logic [DRN_W-1:0] DRAIN = DRN_W'(FRAME_LEN + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FRAME_LEN - 1);

  ctl_t             ctl_d;
  logic [DRN_W-1:0] drn_q, drn_d;
  logic [IDX_W-1:0] idx_d;
  logic             idle, w_en, w_stop, w_start;

  assign idle    = !ctl.start && !ctl.stop;
  assign w_en    = wfield[B_EN - B_PAT];
  assign w_stop  = wfield[B_STOP - B_PAT];
  assign w_start = wfield[B_START - B_PAT];

  assign tx_valid = ctl.en && (ctl.start || (ctl.stop && tx_idx != '0));
  assign tx_last  = tx_valid && (tx_idx == IDX_END);

  always_comb begin
    ctl_d = ctl;
    drn_d = drn_q;
    clr   = 1'b0;
    // stop drain countdown
    if (ctl.stop) begin
      if (drn_q <= DRN_W'(1)) begin
        ctl_d.stop = 1'b0;
        drn_d      = '0;
      end else begin
        drn_d = drn_q - 1'b1;
      end
    end
    // software write takes precedence over the drain
    if (ctl_we) begin
      ctl_d.en = w_en;
      if (idle) begin
        ctl_d.pat  = pat_e'(wfield[1:0]);
        ctl_d.wide = wfield[B_WIDE - B_PAT];
      end
      if (!w_en) begin
        ctl_d.start = 1'b0;
        ctl_d.stop  = 1'b0;
        drn_d       = '0;
      end else if (w_stop) begin
        ctl_d.start = 1'b0;
        ctl_d.stop  = 1'b1;
        drn_d       = DRAIN;
      end else if (w_start && idle) begin
        ctl_d.start = 1'b1;
        clr         = 1'b1;
      end
    end
  end

  always_comb begin
    idx_d = tx_idx;
    if (!ctl.en)        idx_d = '0;
    else if (tx_valid)  idx_d = (tx_idx == IDX_END) ? '0 : tx_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      drn_q  <= '0;
      tx_idx <= '0;
    end else begin
      ctl    <= ctl_d;
      drn_q  <= drn_d;
      tx_idx <= idx_d;
    end
  end
endmodule

// File: rtl/bist_lane.sv
module bist_lane
  import bist_pkg::*;
#(
  parameter int LANE      = 0,
  parameter int FRAME_LEN = 8,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  pat_e             pat,
  input  logic             wide,
  input  logic             tx_valid,
  input  logic [IDX_W-1:0] tx_idx,
  input  logic             inj,
  output logic             frm_inc,
  output logic             err_inc
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FRAME_LEN - 1);

  logic [SYM_W-1:0] tx_sym, exp_sym, lb_q, lb_d;
  logic             lbv_q, lbv_d;
  logic [IDX_W-1:0] ck_q, ck_d;

  // generator and loopback with injection
  assign tx_sym = pat_sym(pat, wide, 8'(LANE), 8'(tx_idx));
  assign lb_d   = tx_sym ^ {{(SYM_W-1){1'b0}}, inj};
  assign lbv_d  = en && tx_valid;

  // checker tracks its own frame position
  assign exp_sym = pat_sym(pat, wide, 8'(LANE), 8'(ck_q));
  assign err_inc = lbv_q && (lb_q != exp_sym);
  assign frm_inc = lbv_q && (ck_q == IDX_END);

  always_comb begin
    ck_d = ck_q;
    if (!en)         ck_d = '0;
    else if (lbv_q)  ck_d = (ck_q == IDX_END) ? '0 : ck_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_q  <= '0;
      lbv_q <= 1'b0;
      ck_q  <= '0;
    end else begin
      lb_q  <= lb_d;
      lbv_q <= lbv_d;
      ck_q  <= ck_d;
    end
  end
endmodule

// File: rtl/bist_engine.sv
module bist_engine
  import bist_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int FRAME_LEN = 8,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 4,
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  input  logic              inj_en,
  input  logic [LANE_W-1:0] inj_lane,
  output logic [LANES-1:0]  lane_pass
);
  localparam int IDX_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam int A_CTL = 0;
  localparam int A_TXF = 1;
  localparam int A_RXF = 2;
  localparam int A_ERR = 2 + LANES;

  ctl_t                         ctl;
  logic                         ctl_we, tx_valid, tx_last, clr;
  logic [IDX_W-1:0]             tx_idx;
  logic                         run_start, run_stop;
  logic [CNT_W-1:0]             txf_q;
  logic [LANES-1:0][CNT_W-1:0]  rxf_q, err_q;
  logic [LANES-1:0]             frm_inc, err_inc;
  logic [15:0]                  ctl_word;
  logic                         unused_rsvd;

  assign ctl_we      = wr_en && (addr == ADDR_W'(A_CTL));
  assign run_start   = ctl.start;
  assign run_stop    = ctl.stop;
  assign unused_rsvd = ^wr_data[B_PAT-1:0];

  bist_ctrl #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .wfield(wr_data[15:B_PAT]),
    .ctl(ctl), .tx_valid(tx_valid), .tx_idx(tx_idx), .tx_last(tx_last), .clr(clr)
  );

  bist_satcnt #(.W(CNT_W)) u_txf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(tx_last), .q(txf_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bist_lane #(.LANE(l), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(ctl.en), .pat(ctl.pat), .wide(ctl.wide),
      .tx_valid(tx_valid), .tx_idx(tx_idx),
      .inj(inj_en && (inj_lane == LANE_W'(l))),
      .frm_inc(frm_inc[l]), .err_inc(err_inc[l])
    );
    bist_satcnt #(.W(CNT_W)) u_rxf (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(frm_inc[l]), .q(rxf_q[l])
    );
    bist_satcnt #(.W(CNT_W)) u_err (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(err_inc[l]), .q(err_q[l])
    );
    assign lane_pass[l] = (err_q[l] == '0) && (rxf_q[l] != '0);
  end

  always_comb begin
    ctl_word                  = '0;
    ctl_word[B_START]         = ctl.start;
    ctl_word[B_STOP]          = ctl.stop;
    ctl_word[B_EN]            = ctl.en;
    ctl_word[B_WIDE]          = ctl.wide;
    ctl_word[B_PAT +: 2]      = ctl.pat;
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(A_CTL))      rd_data = ctl_word;
    else if (addr == ADDR_W'(A_TXF)) rd_data = 16'(txf_q);
    for (int l = 0; l < LANES; l++) begin
      if (addr == ADDR_W'(A_RXF + l)) rd_data = 16'(rxf_q[l]);
      if (addr == ADDR_W'(A_ERR + l)) rd_data = 16'(err_q[l]);
    end
  end
endmodule

// File: rtl/bist_engine_chk.sv
module bist_engine_chk #(
  parameter int LANES     = 4,
  parameter int FRAME_LEN = 8,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           addr,
  input logic                        wr_en,
  input logic                        w_en_bit,
  input logic                        w_stop_bit,
  input logic                        start,
  input logic                        stop,
  input logic                        tx_valid,
  input logic                        clr,
  input logic [LANES-1:0][CNT_W-1:0] err_q
);
  localparam int CW = $clog2(FRAME_LEN + 3);

  logic            ctl_wr, stop_wr;
  logic [CW-1:0]   stop_len;

  assign ctl_wr  = wr_en && (addr == '0);
  assign stop_wr = ctl_wr && w_en_bit && w_stop_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stop_len <= '0;
    else if (stop_wr)    stop_len <= CW'(1);
    else if (stop)       stop_len <= stop_len + 1'b1;
    else                 stop_len <= '0;
  end

  a_r4_stop_drops_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop) |-> !start);

  a_r4_drain_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> (stop_len <= CW'(FRAME_LEN + 1)));

  a_r3_start_held: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ctl_wr) |=> start);

  a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !w_en_bit) |=> (!start && !stop));

  a_r12_tx_only_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (start || stop));

  for (genvar l = 0; l < LANES; l++) begin : g_sat
    a_r9_err_holds_max: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(err_q[l]) == {CNT_W{1'b1}} && !$past(clr)) |-> (err_q[l] == {CNT_W{1'b1}}));
  end
endmodule

bind bist_engine bist_engine_chk #(
  .LANES(LANES), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
  .w_en_bit(wr_data[13]), .w_stop_bit(wr_data[14]),
  .start(run_start), .stop(run_stop), .tx_valid(tx_valid), .clr(clr), .err_q(err_q)
);

// File: tb/test_bist_engine.sv
`timescale 1ns/1ps
module test_bist_engine;
  localparam int NL = 4;
  localparam int FL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        inj_en = 1'b0;
  logic [1:0]  inj_lane = '0;
  logic [3:0]  lane_pass;

  int n_vec = 0, n_bad = 0;
  bit cmp_on = 0, done = 0;

  always #2.5 clk = ~clk;

  bist_engine #(.LANES(NL), .FRAME_LEN(FL), .CNT_W(16), .ADDR_W(4)) i_bist_engine (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .inj_en(inj_en), .inj_lane(inj_lane), .lane_pass(lane_pass)
  );

  // ---------------- behavioural reference model ----------------
  bit m_en, m_start, m_stop, m_wide, m_rxv;
  int m_pat, m_dcnt, m_sym, m_rxcnt, m_txf;
  bit m_inj[NL];
  int m_rxf[NL], m_err[NL];

  function automatic int sat(int v);
    return (v >= 16'hFFFF) ? 16'hFFFF : v + 1;
  endfunction

  task automatic model_reset();
    m_en = 0; m_start = 0; m_stop = 0; m_wide = 0; m_rxv = 0;
    m_pat = 0; m_dcnt = 0; m_sym = 0; m_rxcnt = 0; m_txf = 0;
    for (int l = 0; l < NL; l++) begin m_inj[l] = 0; m_rxf[l] = 0; m_err[l] = 0; end
  endtask

  task automatic model_step();
    bit txv, cw, go, ns, nst, nen, nwide;
    int nd, npat, nsym, nrxcnt;
    txv = m_en && (m_start || (m_stop && m_sym != 0));
    cw  = wr_en && addr == 0;
    go  = cw && wr_data[13] && !wr_data[14] && wr_data[15] && !m_start && !m_stop;
    if (go) begin
      m_txf = 0;
      for (int l = 0; l < NL; l++) begin m_rxf[l] = 0; m_err[l] = 0; end
    end else begin
      if (txv && m_sym == FL-1) m_txf = sat(m_txf);
      for (int l = 0; l < NL; l++) begin
        if (m_rxv && m_inj[l]) m_err[l] = sat(m_err[l]);
        if (m_rxv && m_rxcnt == FL-1) m_rxf[l] = sat(m_rxf[l]);
      end
    end
    nrxcnt = !m_en ? 0 : (m_rxv ? (m_rxcnt + 1) % FL : m_rxcnt);
    nsym   = !m_en ? 0 : (txv ? (m_sym + 1) % FL : m_sym);
    ns = m_stop; nd = m_dcnt; nst = m_start; nen = m_en; npat = m_pat; nwide = m_wide;
    if (m_stop) begin
      if (m_dcnt <= 1) begin ns = 0; nd = 0; end else nd = m_dcnt - 1;
    end
    if (cw) begin
      nen = wr_data[13];
      if (!m_start && !m_stop) begin npat = int'(wr_data[11:10]); nwide = wr_data[12]; end
      if (!wr_data[13]) begin nst = 0; ns = 0; nd = 0; end
      else if (wr_data[14]) begin nst = 0; ns = 1; nd = FL + 1; end
      else if (go) nst = 1;
    end
    for (int l = 0; l < NL; l++) m_inj[l] = inj_en && (inj_lane == l);
    m_rxv = m_en && txv;
    m_rxcnt = nrxcnt; m_sym = nsym;
    m_stop = ns; m_dcnt = nd; m_start = nst; m_en = nen; m_pat = npat; m_wide = nwide;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  function automatic logic [15:0] exp_rd(int a);
    if (a == 0) return {m_start, m_stop, m_en, m_wide, 2'(m_pat), 10'b0};
    if (a == 1) return 16'(m_txf);
    if (a >= 2 && a < 2 + NL) return 16'(m_rxf[a-2]);
    if (a >= 2 + NL && a < 2 + 2*NL) return 16'(m_err[a-2-NL]);
    return 16'h0;
  endfunction

  function automatic logic [3:0] exp_pass();
    logic [3:0] p;
    for (int l = 0; l < NL; l++) p[l] = (m_err[l] == 0) && (m_rxf[l] != 0);
    return p;
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s @%0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (cmp_on && !done) begin
      chk((addr == 0) ? "R2 ctl" : (addr < 6) ? "R6 frames" : "R7 errors",
          rd_data, exp_rd(int'(addr)));
      chk("R10 pass", 16'(lane_pass), 16'(exp_pass()));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int a, logic [15:0] d);
    @(negedge clk); addr = 4'(a); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_is(int a, string tag, logic [15:0] exp);
    @(negedge clk); addr = 4'(a); #1; chk(tag, rd_data, exp);
  endtask

  task automatic rd_val(int a, output logic [15:0] v);
    @(negedge clk); addr = 4'(a); #1; v = rd_data;
  endtask

  task automatic run(int n);
    repeat (n) begin @(negedge clk); addr = 4'((int'(addr) + 1) % 10); end
  endtask

  task automatic inject(int l);
    @(negedge clk); inj_en = 1'b1; inj_lane = 2'(l);
    @(negedge clk); inj_en = 1'b0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [15:0] v, t;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    // R1: reset state
    for (int a = 0; a < 10; a++) rd_is(a, "R1 reset", 16'h0);
    @(negedge clk); #1; chk("R1 pass flags", 16'(lane_pass), 16'h0);

    // R2: field readback, reserved bits read 0
    wr(0, 16'h3800);
    rd_is(0, "R2 fields", 16'h3800);
    wr(0, 16'h3BFF);
    rd_is(0, "R2 reserved", 16'h3800);

    // R3: start, held across a write of 0 to bit 15
    wr(0, 16'hB800);
    rd_is(0, "R3 start", 16'hB800);
    run(37);
    inject(2); run(5); inject(2); run(3); inject(0); run(6); inject(2);
    wr(0, 16'h3400);                       // no start, new type: ignored while running
    rd_is(0, "R3 start held / R2 frozen", 16'hB800);
    // R11: counter writes ignored
    rd_val(1, t);
    wr(1, 16'hFFFF);
    wr(7, 16'h1234);
    rd_is(7, "R11 err1 untouched", 16'h0);
    rd_val(1, v);
    chk("R11 txf not loaded", 16'(v != 16'hFFFF), 16'h1);
    run(3);

    // R4: stop request mid-frame, injection during the drain
    wr(0, 16'h7800);
    n = 0;
    addr = 0; #1;
    chk("R4 stop set, start cleared", rd_data, 16'h7800);
    inj_en = 1'b1; inj_lane = 2'd1;
    while (rd_data[14] && n < 100) begin
      n++;
      @(negedge clk); inj_en = 1'b0; #1;
    end
    chk("R4 stop length", 16'(n), 16'(FL + 1));
    rd_is(0, "R4 stop cleared", 16'h3800);
    rd_val(1, t);
    chk("R6 frames sent", 16'(t != 0), 16'h1);
    for (int l = 0; l < NL; l++) begin
      rd_val(2 + l, v);
      chk("R12 rx frames equal tx", v, t);
    end
    rd_is(8, "R7 lane2 errors", 16'd3);
    rd_is(6, "R7 lane0 errors", 16'd1);
    rd_is(9, "R7 lane3 errors", 16'd0);
    chk("R10 lane3 pass", 16'(lane_pass[3]), 16'h1);
    chk("R10 lane2 fail", 16'(lane_pass[2]), 16'h0);

    // R7: injection while idle has no effect
    rd_val(9, v);
    inj_en = 1'b1; inj_lane = 2'd3; run(6); inj_en = 1'b0; run(2);
    rd_is(9, "R7 idle injection ignored", v);

    // R8: restart clears every counter
    wr(0, 16'hB800);
    rd_is(8, "R8 err2 cleared", 16'h0);
    rd_is(6, "R8 err0 cleared", 16'h0);
    run(13);

    // R5: disable aborts the run
    wr(0, 16'h0000);
    rd_is(0, "R5 disabled", 16'h1800);
    run(20);
    rd_val(1, v); run(10);
    rd_is(1, "R5 frames frozen", v);

    // R9: saturation with type 3, 8-bit symbols, injection every cycle
    wr(0, 16'hAC00);
    rd_is(0, "R2 type3 narrow", 16'hAC00);
    inj_en = 1'b1; inj_lane = 2'd3;
    run(65600);
    inj_en = 1'b0;
    wr(0, 16'h6C00);
    run(FL + 4);
    rd_is(9, "R9 error saturates", 16'hFFFF);
    rd_is(6, "R9 other lane clean", 16'h0);
    chk("R10 lane3 fails", 16'(lane_pass[3]), 16'h0);
    chk("R10 lane0 passes", 16'(lane_pass[0]), 16'h1);
    run(4);
    finish_up();
  end
endmodule